// File: doc/BRIEF.md
# DDR SDRAM Power-Up Sequencer

This block sits on the controller side of a DDR SDRAM interface and owns the memory pins from reset until the device is ready for traffic. While reset is held and for a programmable settle time after it, clock-enable stays low. The sequencer then raises clock-enable and drives a fixed series of commands: precharge-all, a DLL-enable write to the extended mode register, a main mode write that resets the DLL, a lock wait, a second precharge-all, a burst of auto-refresh commands and a final mode write that loads the operating configuration. Every cycle that carries no command carries a NOP.

All waits are cycle counts given by parameters. These are the settle time, the precharge time, the refresh cycle time, the mode-write recovery and the DLL lock time. A parameter can drop the separate DLL-reset write, and the lock wait then follows the DLL-enable write. Once the last recovery gap has passed, `init_done` rises and stays high, and the pins hold NOP until a new reset.

All pin outputs come from registers. A synchronous active-high reset returns the block to its clock-enable-low waiting state from any point in the sequence.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While reset is high the outputs are cke=0, NOP, ba=0, addr=0 and init_done=0. After reset is released, cke stays low and NOP is driven for at least STARTUP_CYC cycles. NOP is cs_n=0, ras_n=1, cas_n=1, we_n=1.
- R2: cke rises in a cycle that carries NOP. The next cycle carries precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, addr bit 10 high, other addr bits 0, ba=0). cke then stays high until reset.
- R3: A mode-type write is cs_n, ras_n, cas_n and we_n all low. ba[0]=1 selects the extended register and ba[0]=0 selects the main register.
- R4: The first mode-type write goes to the extended register (ba=2'b01) exactly TRP_CYC cycles after the first precharge-all. Its addr is all zero except bit 1, which equals DRIVE_HALF (0 = full drive strength).
- R5: With SKIP_DLL_RESET=0, a main mode write with addr = MODE_WORD with bit 8 forced high and ba=0 follows the extended write after MRD_CYC cycles. The second precharge-all follows it after DLL_LOCK_CYC cycles. With SKIP_DLL_RESET=1 there is no DLL-reset write, and the second precharge-all follows the extended write after DLL_LOCK_CYC cycles.
- R6: The cycle right after any mode-type write carries NOP.
- R7: REF_COUNT auto-refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=1) follow the second precharge-all. The first comes TRP_CYC cycles after it, and each later one TRFC_CYC cycles after the one before.
- R8: The final mode write comes TRFC_CYC cycles after the last refresh, with ba=0 and addr = MODE_WORD with bit 8 forced low.
- R9: init_done rises exactly MRD_CYC cycles after the final mode write. After that it stays high and only NOP is driven.
- R10: Raising reset in the middle of the sequence brings back cke=0, NOP and init_done=0 on the next clock. After release the full sequence runs again from the start.
- R11: No pin pattern other than NOP, precharge-all, mode write or auto-refresh ever appears, and no command appears outside the listed order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address; bit 0 picks extended or main mode register |
| addr | output | ADDR_W | Address bus, carries mode words and the precharge-all flag |
| init_done | output | 1 | High once initialization has completed |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of a gap, after the extended write but before the refreshes. The timer, the refresh counter and the registered pins must then all restart together. The bench lets a complete run finish and then waits a fixed number of cycles past the second clock-enable rise. It raises reset there, checks the pins one clock later, and reloads the expected command list so the rerun is compared from its first precharge. A second instance built with the DLL-reset write skipped runs in parallel, so the bench can measure the alternative lock-wait placement.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_PREA = 2'd1,
    OP_MRS  = 2'd2,
    OP_REF  = 2'd3
  } seq_op_e;

  typedef enum logic [3:0] {
    S_WAIT_PWR = 4'd0,
    S_CKE_UP   = 4'd1,
    S_PRE1     = 4'd2,
    S_G_PRE1   = 4'd3,
    S_EMRS     = 4'd4,
    S_G_EMRS   = 4'd5,
    S_MRS_DLL  = 4'd6,
    S_G_LOCK   = 4'd7,
    S_PRE2     = 4'd8,
    S_G_PRE2   = 4'd9,
    S_REF      = 4'd10,
    S_G_REF    = 4'd11,
    S_MRS_OP   = 4'd12,
    S_G_MRS_OP = 4'd13,
    S_DONE     = 4'd14
  } seq_state_e;

endpackage

// File: rtl/init_gap_timer.sv
module init_gap_timer #(
  parameter int CW      = 16,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= CW'(RST_VAL);
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // once drained and not reloaded, the count must not wrap
  assert_timer_floor_R7: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);

endmodule

// File: rtl/init_seq_fsm.sv
module init_seq_fsm
  import ddr_init_pkg::*;
#(
  parameter int          ADDR_W         = 12,
  parameter int          CW             = 16,
  parameter int          TRP_CYC        = 3,
  parameter int          TRFC_CYC       = 9,
  parameter int          MRD_CYC        = 2,
  parameter int          DLL_LOCK_CYC   = 200,
  parameter int          REF_COUNT      = 2,
  parameter logic [11:0] MODE_WORD      = 12'h031,
  parameter bit          DRIVE_HALF     = 1'b0,
  parameter bit          SKIP_DLL_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              t_zero,
  output logic              t_load,
  output logic [CW-1:0]     t_val,
  output seq_op_e           op,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cke_o,
  output logic              done_o
);

  localparam int TRP_G  = (TRP_CYC < 2) ? 2 : TRP_CYC;
  localparam int TRFC_G = (TRFC_CYC < 2) ? 2 : TRFC_CYC;
  localparam int MRD_G  = (MRD_CYC < 2) ? 2 : MRD_CYC;
  localparam int LOCK_G = (DLL_LOCK_CYC < MRD_G) ? MRD_G : DLL_LOCK_CYC;
  localparam int RW     = $clog2(REF_COUNT + 1);

  localparam logic [ADDR_W-1:0] BIT_A8    = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] BIT_A10   = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] MODE_BASE = ADDR_W'(MODE_WORD);
  localparam logic [ADDR_W-1:0] MODE_RST  = MODE_BASE | BIT_A8;
  localparam logic [ADDR_W-1:0] MODE_RUN  = MODE_BASE & ~BIT_A8;
  localparam logic [ADDR_W-1:0] EXT_WORD  = ADDR_W'({DRIVE_HALF, 1'b0});

  seq_state_e       state, state_nx;
  logic [RW-1:0]    ref_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_WAIT_PWR;
      ref_cnt <= '0;
    end else begin
      state <= state_nx;
      if (state == S_REF)
        ref_cnt <= ref_cnt + 1'b1;
    end
  end

  always_comb begin
    state_nx = state;
    op       = OP_NOP;
    ba_o     = 2'b00;
    addr_o   = '0;
    cke_o    = 1'b1;
    done_o   = 1'b0;
    t_load   = 1'b0;
    t_val    = '0;
    unique case (state)
      S_WAIT_PWR: begin
        cke_o = 1'b0;
        if (t_zero) state_nx = S_CKE_UP;
      end
      S_CKE_UP: state_nx = S_PRE1;
      S_PRE1: begin
        op       = OP_PREA;
        addr_o   = BIT_A10;
        t_load   = 1'b1;
        t_val    = CW'(TRP_G - 2);
        state_nx = S_G_PRE1;
      end
      S_G_PRE1: if (t_zero) state_nx = S_EMRS;
      S_EMRS: begin
        op     = OP_MRS;
        ba_o   = 2'b01;
        addr_o = EXT_WORD;
        t_load = 1'b1;
        if (SKIP_DLL_RESET) begin
          t_val    = CW'(LOCK_G - 2);
          state_nx = S_G_LOCK;
        end else begin
          t_val    = CW'(MRD_G - 2);
          state_nx = S_G_EMRS;
        end
      end
      S_G_EMRS: if (t_zero) state_nx = S_MRS_DLL;
      S_MRS_DLL: begin
        op       = OP_MRS;
        addr_o   = MODE_RST;
        t_load   = 1'b1;
        t_val    = CW'(LOCK_G - 2);
        state_nx = S_G_LOCK;
      end
      S_G_LOCK: if (t_zero) state_nx = S_PRE2;
      S_PRE2: begin
        op       = OP_PREA;
        addr_o   = BIT_A10;
        t_load   = 1'b1;
        t_val    = CW'(TRP_G - 2);
        state_nx = S_G_PRE2;
      end
      S_G_PRE2: if (t_zero) state_nx = S_REF;
      S_REF: begin
        op       = OP_REF;
        t_load   = 1'b1;
        t_val    = CW'(TRFC_G - 2);
        state_nx = S_G_REF;
      end
      S_G_REF: begin
        if (t_zero)
          state_nx = (ref_cnt >= RW'(REF_COUNT)) ? S_MRS_OP : S_REF;
      end
      S_MRS_OP: begin
        op       = OP_MRS;
        addr_o   = MODE_RUN;
        t_load   = 1'b1;
        t_val    = CW'(MRD_G - 2);
        state_nx = S_G_MRS_OP;
      end
      S_G_MRS_OP: if (t_zero) state_nx = S_DONE;
      S_DONE: done_o = 1'b1;
      default: state_nx = S_WAIT_PWR;
    endcase
  end

  // the refresh tally never runs past its programmed count
  assert_ref_bound_R7: assert property (@(posedge clk) disable iff (rst)
    ref_cnt <= RW'(REF_COUNT));

endmodule

// File: rtl/init_pin_drive.sv
module init_pin_drive
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_op_e           op,
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cke_i,
  input  logic              done_i,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  logic [2:0] strobes;

  always_comb begin
    unique case (op)
      OP_PREA: strobes = 3'b010;
      OP_MRS:  strobes = 3'b000;
      OP_REF:  strobes = 3'b001;
      default: strobes = 3'b111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke       <= 1'b0;
      cs_n      <= 1'b0;
      {ras_n, cas_n, we_n} <= 3'b111;
      ba        <= 2'b00;
      addr      <= '0;
      init_done <= 1'b0;
    end else begin
      cke       <= cke_i;
      cs_n      <= 1'b0;
      {ras_n, cas_n, we_n} <= strobes;
      ba        <= ba_i;
      addr      <= addr_i;
      init_done <= done_i;
    end
  end

  assert_nop_cke_low_R1: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (!cs_n && ras_n && cas_n && we_n));

  assert_cke_hold_R2: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  assert_nop_after_mrs_R6: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && !cas_n && !we_n) |=> (ras_n && cas_n && we_n));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
    init_done |=> (init_done && ras_n && cas_n && we_n));

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
  import ddr_init_pkg::*;
#(
  parameter int          ADDR_W         = 12,
  parameter int          STARTUP_CYC    = 25000,
  parameter int          TRP_CYC        = 3,
  parameter int          TRFC_CYC       = 9,
  parameter int          MRD_CYC        = 2,
  parameter int          DLL_LOCK_CYC   = 200,
  parameter int          REF_COUNT      = 2,
  parameter logic [11:0] MODE_WORD      = 12'h031,
  parameter bit          DRIVE_HALF     = 1'b0,
  parameter bit          SKIP_DLL_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int START_G = (STARTUP_CYC < 1) ? 1 : STARTUP_CYC;
  localparam int M1      = (START_G > DLL_LOCK_CYC) ? START_G : DLL_LOCK_CYC;
  localparam int M2      = (M1 > TRFC_CYC) ? M1 : TRFC_CYC;
  localparam int M3      = (M2 > TRP_CYC) ? M2 : TRP_CYC;
  localparam int MAXV    = (M3 > MRD_CYC) ? M3 : MRD_CYC;
  localparam int CW      = $clog2(MAXV + 1);

  logic              t_zero, t_load;
  logic [CW-1:0]     t_val;
  seq_op_e           op;
  logic [1:0]        ba_c;
  logic [ADDR_W-1:0] addr_c;
  logic              cke_c, done_c;

  init_gap_timer #(.CW(CW), .RST_VAL(START_G - 1)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  init_seq_fsm #(
    .ADDR_W(ADDR_W), .CW(CW), .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC),
    .MRD_CYC(MRD_CYC), .DLL_LOCK_CYC(DLL_LOCK_CYC), .REF_COUNT(REF_COUNT),
    .MODE_WORD(MODE_WORD), .DRIVE_HALF(DRIVE_HALF), .SKIP_DLL_RESET(SKIP_DLL_RESET)
  ) u_fsm (
    .clk(clk), .rst(rst), .t_zero(t_zero), .t_load(t_load), .t_val(t_val),
    .op(op), .ba_o(ba_c), .addr_o(addr_c), .cke_o(cke_c), .done_o(done_c)
  );

  init_pin_drive #(.ADDR_W(ADDR_W)) u_pins (
    .clk(clk), .rst(rst), .op(op), .ba_i(ba_c), .addr_i(addr_c),
    .cke_i(cke_c), .done_i(done_c), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
  );

endmodule

// File: tb/tb_ddr_pwrup_seq.sv
module tb_ddr_pwrup_seq;

  localparam int          STARTUP = 300;
  localparam int          TRP     = 3;
  localparam int          TRFC    = 9;
  localparam int          MRD     = 2;
  localparam int          LOCK    = 200;
  localparam int          NREF    = 2;
  localparam logic [11:0] MODE    = 12'h031;

  localparam int C_NOP = 0, C_PREA = 1, C_MRS = 2, C_REF = 3, C_BAD = 4;

  typedef struct {
    int          op;
    logic [1:0]  ba;
    logic [11:0] addr;
    int          gap;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [11:0] addr;
  logic s_cke, s_cs_n, s_ras_n, s_cas_n, s_we_n, s_done;
  logic [1:0] s_ba;
  logic [11:0] s_addr;

  ddr_pwrup_seq #(.STARTUP_CYC(STARTUP), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
    .MRD_CYC(MRD), .DLL_LOCK_CYC(LOCK), .REF_COUNT(NREF), .MODE_WORD(MODE)) dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done));

  ddr_pwrup_seq #(.STARTUP_CYC(20), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
    .MRD_CYC(MRD), .DLL_LOCK_CYC(LOCK), .REF_COUNT(NREF), .MODE_WORD(MODE),
    .SKIP_DLL_RESET(1'b1)) dut_skip (
    .clk(clk), .rst(rst), .cke(s_cke), .cs_n(s_cs_n), .ras_n(s_ras_n),
    .cas_n(s_cas_n), .we_n(s_we_n), .ba(s_ba), .addr(s_addr), .init_done(s_done));

  int checks = 0;
  int errors = 0;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int decode(input logic c, r, a, w);
    case ({c, r, a, w})
      4'b0111: return C_NOP;
      4'b0010: return C_PREA;
      4'b0000: return C_MRS;
      4'b0001: return C_REF;
      default: return C_BAD;
    endcase
  endfunction

  // driver side of the scoreboard: expected command list with spacing
  task automatic push_plan();
    exp_t e;
    exp_q.delete();
    e = '{C_PREA, 2'b00, 12'h400, 1,    "R2"}; exp_q.push_back(e);
    e = '{C_MRS,  2'b01, 12'h000, TRP,  "R4"}; exp_q.push_back(e);
    e = '{C_MRS,  2'b00, MODE | 12'h100, MRD, "R5"}; exp_q.push_back(e);
    e = '{C_PREA, 2'b00, 12'h400, LOCK, "R5"}; exp_q.push_back(e);
    e = '{C_REF,  2'b00, 12'h000, TRP,  "R7"}; exp_q.push_back(e);
    for (int i = 1; i < NREF; i++) begin
      e = '{C_REF, 2'b00, 12'h000, TRFC, "R7"}; exp_q.push_back(e);
    end
    e = '{C_MRS,  2'b00, MODE & ~12'h100, TRFC, "R8"}; exp_q.push_back(e);
  endtask

  // monitor side
  int cyc, last_cyc, low_cnt;
  bit cke_seen, done_seen;
  int illegal_cnt = 0, cke_drop_cnt = 0, hold_fail = 0;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; low_cnt = 0; cke_seen = 0; done_seen = 0; last_cyc = 0;
    end else begin
      int code;
      cyc++;
      code = decode(cs_n, ras_n, cas_n, we_n);
      if (code == C_BAD) illegal_cnt++;
      if (!cke_seen) begin
        if (!cke) low_cnt++;
        else begin
          cke_seen = 1;
          chk(low_cnt >= STARTUP, "R1", "cke-low cycles", low_cnt, STARTUP);
          chk(code == C_NOP, "R2", "command with cke rise", code, C_NOP);
          last_cyc = cyc;
        end
      end else begin
        if (!cke) cke_drop_cnt++;
        if (code != C_NOP && code != C_BAD) begin
          if (exp_q.size() == 0) begin
            chk(0, "R11", "unexpected command", code, C_NOP);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(code == e.op, e.req, "command kind", code, e.op);
            chk(ba == e.ba, e.req, "bank address", ba, e.ba);
            chk(addr == e.addr, e.req, "address", addr, e.addr);
            chk(cyc - last_cyc == e.gap, e.req, "spacing", cyc - last_cyc, e.gap);
            if (code == C_MRS)
              chk(e.op == C_MRS, "R3", "mode write encoding", code, e.op);
          end
          last_cyc = cyc;
        end
        if (init_done && !done_seen) begin
          done_seen = 1;
          chk(cyc - last_cyc == MRD, "R9", "done delay", cyc - last_cyc, MRD);
          chk(exp_q.size() == 0, "R9", "commands left", exp_q.size(), 0);
        end else if (done_seen && !init_done) hold_fail++;
      end
    end
  end

  // logger for the instance without the separate DLL-reset write
  int scyc, s_emrs, s_gap;
  bit s_gap_set, s_dllrst_seen;
  always @(negedge clk) begin
    if (rst) begin
      scyc = 0; s_emrs = -1; s_gap = -1; s_gap_set = 0; s_dllrst_seen = 0;
    end else begin
      int code;
      scyc++;
      code = decode(s_cs_n, s_ras_n, s_cas_n, s_we_n);
      if (code == C_MRS && s_ba == 2'b01) s_emrs = scyc;
      if (code == C_MRS && s_ba == 2'b00 && s_addr[8]) s_dllrst_seen = 1;
      if (code == C_PREA && s_emrs >= 0 && !s_gap_set) begin
        s_gap = scyc - s_emrs; s_gap_set = 1;
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cke == 0 && init_done == 0, "R1", "reset cke/done", {cke, init_done}, 0);
    chk(decode(cs_n, ras_n, cas_n, we_n) == C_NOP, "R1", "reset command",
        decode(cs_n, ras_n, cas_n, we_n), C_NOP);
    chk(ba == 0 && addr == 0, "R1", "reset ba/addr", {ba, addr}, 0);
    push_plan();
    @(posedge clk); #1 rst = 1'b0;

    wait (s_done == 1'b1);
    @(negedge clk);
    chk(s_gap == LOCK, "R5", "skip-mode lock spacing", s_gap, LOCK);
    chk(s_dllrst_seen == 0, "R5", "skip-mode dll reset write", s_dllrst_seen, 0);

    wait (done_seen == 1'b1);
    repeat (30) @(negedge clk);
    chk(init_done == 1, "R9", "done held", init_done, 1);
    chk(hold_fail == 0, "R9", "done drops", hold_fail, 0);
    chk(cke_drop_cnt == 0, "R2", "cke drops", cke_drop_cnt, 0);

    // R10: reset in the middle of the lock wait
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    push_plan();
    #1 rst = 1'b0;
    wait (cke_seen == 1'b1);
    repeat (TRP + 20) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(cke == 0 && init_done == 0, "R10", "mid-run reset cke/done",
        {cke, init_done}, 0);
    chk(decode(cs_n, ras_n, cas_n, we_n) == C_NOP, "R10", "mid-run reset command",
        decode(cs_n, ras_n, cas_n, we_n), C_NOP);
    push_plan();
    @(posedge clk); #1 rst = 1'b0;
    wait (done_seen == 1'b1);
    repeat (10) @(negedge clk);
    chk(init_done == 1, "R10", "rerun completes", init_done, 1);
    chk(exp_q.size() == 0, "R10", "rerun commands left", exp_q.size(), 0);
    chk(illegal_cnt == 0, "R11", "illegal pin patterns", illegal_cnt, 0);
    chk(cke_drop_cnt == 0, "R2", "cke drops after rerun", cke_drop_cnt, 0);
    summary();
    $finish;
  end

endmodule